// File: doc/BRIEF.md
# ECC error capture and interrupt controller

This block sits next to an ECC-protected on-chip memory and turns the decoder's single-cycle error pulses into software-visible state. Two error classes are handled: correctable (CE) and uncorrectable (UE). Each class has a sticky status bit and its own first-failure capture bank. The bank holds the failing address offset, the failing data word and the syndrome from the first error of that class. A single level interrupt is the OR of the status bits whose mask bits are clear.

Software reaches the block through a flat 32-bit register port: a write strobe, a byte offset, write data and combinational read data. Status bits are cleared by writing ones. The mask cannot be written directly: separate enable and disable strobe registers clear and set its bits. Every report is gated by an ECC enable bit. The stored address is only the offset inside the memory region, so software adds the region base itself.

Top module: `memerr_irq_ctrl`

## Requirements
- R1: After reset the status register (0x04) reads 0, the mask register (0x08) reads 0xC0 (both classes masked), the ECC control register (0x14) reads 0, every capture register reads 0 and `irq` is low.
- R2: Bit 0 of 0x14 is the ECC enable, readable and writable. While it is 0, error pulses set no status bit and load no capture bank.
- R3: With ECC enabled, a `ce_evt` pulse sets status bit 6 and a `ue_evt` pulse sets status bit 7. The bit reads as set from the clock edge that samples the pulse.
- R4: Writing 0x04 clears each status bit (6 or 7) written as 1 and leaves any bit written as 0 unchanged.
- R5: Writing 1 to bit 6 or 7 of 0x0C clears that mask bit, and writing 1 to the same bit of 0x10 sets it. Zero bits in either write have no effect. Writes to 0x08 do not change the mask.
- R6: `irq` is high exactly when some status bit among 6 and 7 is set and its mask bit is clear.
- R7: The CE bank reads at these offsets: address offset at 0x1C (zero-extended), data bits 31:0 at 0x20, data bits 63:32 at 0x24 and syndrome at 0x30 (zero-extended). The UE bank uses 0x34, 0x38, 0x3C and 0x48 for the same fields.
- R8: A bank loads only on an enabled error of its class while that class's status bit is clear. Later errors of the class leave the bank unchanged until software clears the status bit.
- R9: If an enabled error and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R10: CE and UE pulses in the same cycle set both status bits, and each bank captures the presented fields independently.
- R11: Data slots beyond the data width (0x28, 0x2C, 0x40, 0x44) and unmapped offsets such as 0x18, 0x4C and 0xFC read 0.
- R12: Offset 0x00 is a 32-bit read/write error-control word. Writing it changes neither the status nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| ce_evt | input | 1 | Correctable-error pulse from the decoder |
| ue_evt | input | 1 | Uncorrectable-error pulse from the decoder |
| err_addr | input | AW (18) | Failing address offset |
| err_data | input | DW (64) | Failing data word |
| err_syn | input | SW (8) | Failing syndrome |
| irq | output | 1 | Level interrupt |

## Verification
Capture is tried with a lone CE pulse, a lone UE pulse, simultaneous CE and UE pulses, and a second pulse of the same class with different fields. Together these separate the class routing of each bank, the byte order of the two data words and the first-failure hold. Status clearing is exercised with one bit written at a time, with a write that collides with a fresh error, and with ECC disabled. This tells a correct write-one-to-clear apart from a clear of the whole register, and shows which side wins a collision. Mask patterns walk enable, disable, zero writes and direct writes to the read-only mask while status is set, so `irq` shows the gating of each class on its own.

// File: rtl/memerr_pkg.sv
package memerr_pkg;
  localparam int NCLS       = 2;   // index 0 = correctable, 1 = uncorrectable
  localparam int IRQ_LSB    = 6;   // status/mask bits 7:6
  localparam int DWORDS_MAX = 4;   // data slots per capture bank

  localparam logic [7:0] OFF_ERRCTL = 8'h00;
  localparam logic [7:0] OFF_STS    = 8'h04;
  localparam logic [7:0] OFF_MSK    = 8'h08;
  localparam logic [7:0] OFF_IEN    = 8'h0C;
  localparam logic [7:0] OFF_IDS    = 8'h10;
  localparam logic [7:0] OFF_ECC    = 8'h14;

  typedef enum int {CLS_CE = 0, CLS_UE = 1} err_cls_e;

  // Start offset of a capture bank: address, then data words, then syndrome.
  function automatic logic [7:0] bank_base(int cls);
    return (cls == CLS_UE) ? 8'h34 : 8'h1C;
  endfunction

  function automatic logic [7:0] bank_data_off(int cls, int w);
    return bank_base(cls) + 8'(4 + 4 * w);
  endfunction

  function automatic logic [7:0] bank_syn_off(int cls);
    return bank_base(cls) + 8'(4 + 4 * DWORDS_MAX);
  endfunction

  // Sticky status: a set from hardware outranks a clear from software.
  function automatic logic [NCLS-1:0] sts_next(logic [NCLS-1:0] cur,
                                               logic [NCLS-1:0] set,
                                               logic [NCLS-1:0] clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic [NCLS-1:0] msk_next(logic [NCLS-1:0] cur,
                                               logic [NCLS-1:0] unmask,
                                               logic [NCLS-1:0] domask);
    return (cur & ~unmask) | domask;
  endfunction

  function automatic logic irq_of(logic [NCLS-1:0] sts, logic [NCLS-1:0] msk);
    return |(sts & ~msk);
  endfunction

  function automatic logic [31:0] word_of(logic [DWORDS_MAX*32-1:0] d, int w);
    return d[w*32 +: 32];
  endfunction
endpackage

// File: rtl/memerr_capture.sv
module memerr_capture #(
  parameter int AW = 18,
  parameter int DW = 64,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic [SW-1:0] in_syn,
  output logic [AW-1:0] q_addr,
  output logic [DW-1:0] q_data,
  output logic [SW-1:0] q_syn
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_addr <= '0;
      q_data <= '0;
      q_syn  <= '0;
    end else if (load) begin
      q_addr <= in_addr;
      q_data <= in_data;
      q_syn  <= in_syn;
    end
  end
endmodule

// File: rtl/memerr_irq.sv
module memerr_irq
  import memerr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ecc_en,
  input  logic [NCLS-1:0] evt,
  input  logic [NCLS-1:0] clr,
  input  logic [NCLS-1:0] unmask,
  input  logic [NCLS-1:0] domask,
  output logic [NCLS-1:0] sts_q,
  output logic [NCLS-1:0] msk_q,
  output logic [NCLS-1:0] load,
  output logic            irq
);
  logic [NCLS-1:0] hit;

  assign hit  = evt & {NCLS{ecc_en}};
  assign load = hit & ~sts_q;
  assign irq  = irq_of(sts_q, msk_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      msk_q <= '1;
    end else begin
      sts_q <= sts_next(sts_q, hit, clr);
      msk_q <= msk_next(msk_q, unmask, domask);
    end
  end
endmodule

// File: rtl/memerr_regif.sv
module memerr_regif
  import memerr_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 64,
  parameter int SW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [7:0]                addr,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  input  logic [NCLS-1:0]           sts_q,
  input  logic [NCLS-1:0]           msk_q,
  input  logic [NCLS-1:0][AW-1:0]   cap_addr,
  input  logic [NCLS-1:0][DW-1:0]   cap_data,
  input  logic [NCLS-1:0][SW-1:0]   cap_syn,
  output logic [NCLS-1:0]           clr,
  output logic [NCLS-1:0]           unmask,
  output logic [NCLS-1:0]           domask,
  output logic                      ecc_en
);
  logic [31:0] errctl_q;
  logic [NCLS-1:0] wbits;

  assign wbits  = wdata[IRQ_LSB +: NCLS];
  assign clr    = (wr_en && addr == OFF_STS) ? wbits : '0;
  assign unmask = (wr_en && addr == OFF_IEN) ? wbits : '0;
  assign domask = (wr_en && addr == OFF_IDS) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      errctl_q <= '0;
      ecc_en   <= 1'b0;
    end else if (wr_en) begin
      if (addr == OFF_ERRCTL) errctl_q <= wdata;
      if (addr == OFF_ECC)    ecc_en   <= wdata[0];
    end
  end

  always_comb begin
    logic [DWORDS_MAX*32-1:0] dx;
    rdata = '0;
    dx    = '0;
    case (addr)
      OFF_ERRCTL: rdata = errctl_q;
      OFF_STS:    rdata[IRQ_LSB +: NCLS] = sts_q;
      OFF_MSK:    rdata[IRQ_LSB +: NCLS] = msk_q;
      OFF_ECC:    rdata[0] = ecc_en;
      default: begin
        for (int c = 0; c < NCLS; c++) begin
          dx = '0;
          dx[DW-1:0] = cap_data[c];
          if (addr == bank_base(c)) rdata[AW-1:0] = cap_addr[c];
          if (addr == bank_syn_off(c)) rdata[SW-1:0] = cap_syn[c];
          for (int w = 0; w < DWORDS_MAX; w++) begin
            if (addr == bank_data_off(c, w)) rdata = word_of(dx, w);
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/memerr_irq_ctrl.sv
module memerr_irq_ctrl
  import memerr_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 64,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          ce_evt,
  input  logic          ue_evt,
  input  logic [AW-1:0] err_addr,
  input  logic [DW-1:0] err_data,
  input  logic [SW-1:0] err_syn,
  output logic          irq
);
  logic [NCLS-1:0]         evt;
  logic [NCLS-1:0]         load;
  logic [NCLS-1:0]         sts_q;
  logic [NCLS-1:0]         msk_q;
  logic [NCLS-1:0]         clr;
  logic [NCLS-1:0]         unmask;
  logic [NCLS-1:0]         domask;
  logic                    ecc_en;
  logic [NCLS-1:0][AW-1:0] cap_addr;
  logic [NCLS-1:0][DW-1:0] cap_data;
  logic [NCLS-1:0][SW-1:0] cap_syn;

  assign evt[CLS_CE] = ce_evt;
  assign evt[CLS_UE] = ue_evt;

  memerr_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .ecc_en (ecc_en),
    .evt    (evt),
    .clr    (clr),
    .unmask (unmask),
    .domask (domask),
    .sts_q  (sts_q),
    .msk_q  (msk_q),
    .load   (load),
    .irq    (irq)
  );

  for (genvar c = 0; c < NCLS; c++) begin : g_bank
    memerr_capture #(.AW(AW), .DW(DW), .SW(SW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load[c]),
      .in_addr (err_addr),
      .in_data (err_data),
      .in_syn  (err_syn),
      .q_addr  (cap_addr[c]),
      .q_data  (cap_data[c]),
      .q_syn   (cap_syn[c])
    );
  end

  memerr_regif #(.AW(AW), .DW(DW), .SW(SW)) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .sts_q    (sts_q),
    .msk_q    (msk_q),
    .cap_addr (cap_addr),
    .cap_data (cap_data),
    .cap_syn  (cap_syn),
    .clr      (clr),
    .unmask   (unmask),
    .domask   (domask),
    .ecc_en   (ecc_en)
  );
endmodule

// File: rtl/memerr_irq_ctrl_chk.sv
module memerr_irq_ctrl_chk
  import memerr_pkg::*;
#(
  parameter int AW = 18
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_wr_en,
  input logic [7:0]              reg_addr,
  input logic [31:0]             reg_wdata,
  input logic                    ce_evt,
  input logic                    ue_evt,
  input logic                    ecc_en,
  input logic [NCLS-1:0]         sts_q,
  input logic [NCLS-1:0]         msk_q,
  input logic [NCLS-1:0][AW-1:0] cap_addr,
  input logic                    irq
);
  // R3
  ce_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_en && ce_evt) |=> sts_q[CLS_CE]);

  // R9
  ue_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_en && ue_evt) |=> sts_q[CLS_UE]);

  // R2
  gated_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[CLS_CE]) |-> $past(ecc_en && ce_evt));

  // R8
  first_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[CLS_CE] |=> $stable(cap_addr[CLS_CE]));

  // R4
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == OFF_STS && reg_wdata[IRQ_LSB] && !(ecc_en && ce_evt))
      |=> !sts_q[CLS_CE]);

  // R5
  unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == OFF_IEN && reg_wdata[IRQ_LSB+1]) |=> !msk_q[CLS_UE]);

  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '1) |-> !irq);
endmodule

bind memerr_irq_ctrl memerr_irq_ctrl_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .ce_evt    (ce_evt),
  .ue_evt    (ue_evt),
  .ecc_en    (ecc_en),
  .sts_q     (sts_q),
  .msk_q     (msk_q),
  .cap_addr  (cap_addr),
  .irq       (irq)
);

// File: tb/memerr_irq_ctrl_bench.sv
module memerr_irq_ctrl_bench;
  localparam int AW = 18;
  localparam int DW = 64;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          ce_evt = 1'b0;
  logic          ue_evt = 1'b0;
  logic [AW-1:0] err_addr = '0;
  logic [DW-1:0] err_data = '0;
  logic [SW-1:0] err_syn = '0;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  memerr_irq_ctrl #(.AW(AW), .DW(DW), .SW(SW)) u_memerr_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ce_evt(ce_evt), .ue_evt(ue_evt),
    .err_addr(err_addr), .err_data(err_data), .err_syn(err_syn), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse(bit ce, bit ue, logic [AW-1:0] a, logic [DW-1:0] d, logic [SW-1:0] s);
    @(negedge clk);
    ce_evt = ce; ue_evt = ue; err_addr = a; err_data = d; err_syn = s;
    @(negedge clk);
    ce_evt = 1'b0; ue_evt = 1'b0; err_addr = '0; err_data = '0; err_syn = '0;
  endtask

  task automatic t_reset;
    rd_chk("R1 status after reset", 8'h04, 32'h0);
    rd_chk("R1 mask after reset", 8'h08, 32'hC0);
    rd_chk("R1 ecc ctrl after reset", 8'h14, 32'h0);
    rd_chk("R1 CE addr after reset", 8'h1C, 32'h0);
    rd_chk("R1 UE data lo after reset", 8'h38, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ecc_gate;
    pulse(1'b1, 1'b1, 18'h00123, 64'hAAAA_BBBB_CCCC_DDDD, 8'h11);
    rd_chk("R2 status with ecc off", 8'h04, 32'h0);
    rd_chk("R2 CE bank untouched with ecc off", 8'h1C, 32'h0);
    rd_chk("R2 UE bank untouched with ecc off", 8'h48, 32'h0);
    wr(8'h14, 32'h1);
    rd_chk("R2 ecc enable readback", 8'h14, 32'h1);
  endtask

  task automatic t_ce_capture;
    pulse(1'b1, 1'b0, 18'h1ABCD, 64'h1122_3344_5566_7788, 8'h5A);
    rd_chk("R3 CE status bit 6", 8'h04, 32'h40);
    rd_chk("R7 CE addr", 8'h1C, 32'h0001ABCD);
    rd_chk("R7 CE data lo", 8'h20, 32'h55667788);
    rd_chk("R7 CE data hi", 8'h24, 32'h11223344);
    rd_chk("R7 CE syndrome", 8'h30, 32'h0000005A);
    rd_chk("R11 CE slot 0x28", 8'h28, 32'h0);
    rd_chk("R11 CE slot 0x2C", 8'h2C, 32'h0);
    rd_chk("R7 UE addr untouched", 8'h34, 32'h0);
    chk("R6 irq low while masked", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_first_kept;
    pulse(1'b1, 1'b0, 18'h00042, 64'h0F0F_0F0F_F0F0_F0F0, 8'hE1);
    rd_chk("R8 CE addr kept", 8'h1C, 32'h0001ABCD);
    rd_chk("R8 CE data kept", 8'h20, 32'h55667788);
    rd_chk("R8 CE syndrome kept", 8'h30, 32'h0000005A);
    wr(8'h04, 32'h40);
    rd_chk("R4 CE status cleared", 8'h04, 32'h0);
    pulse(1'b1, 1'b0, 18'h00042, 64'h0F0F_0F0F_F0F0_F0F0, 8'hE1);
    rd_chk("R8 CE addr reloaded", 8'h1C, 32'h00000042);
    rd_chk("R8 CE data hi reloaded", 8'h24, 32'h0F0F0F0F);
  endtask

  task automatic t_w1c;
    // CE status is set on entry
    wr(8'h04, 32'h80);
    rd_chk("R4 writing UE bit leaves CE", 8'h04, 32'h40);
    wr(8'h04, 32'h0);
    rd_chk("R4 writing zero leaves CE", 8'h04, 32'h40);
    wr(8'h04, 32'h40);
    rd_chk("R4 CE cleared by one", 8'h04, 32'h0);
  endtask

  task automatic t_mask_irq;
    pulse(1'b1, 1'b0, 18'h00001, 64'h1, 8'h01);
    chk("R6 irq low with CE masked", {31'b0, irq}, 32'h0);
    wr(8'h0C, 32'h40);
    rd_chk("R5 enable unmasks CE", 8'h08, 32'h80);
    chk("R6 irq high CE unmasked", {31'b0, irq}, 32'h1);
    wr(8'h08, 32'hC0);
    rd_chk("R5 mask write ignored", 8'h08, 32'h80);
    wr(8'h10, 32'h0);
    rd_chk("R5 disable zero no effect", 8'h08, 32'h80);
    wr(8'h0C, 32'h0);
    rd_chk("R5 enable zero no effect", 8'h08, 32'h80);
    pulse(1'b0, 1'b1, 18'h00002, 64'h2, 8'h02);
    wr(8'h04, 32'h40);
    rd_chk("R4 UE remains after CE clear", 8'h04, 32'h80);
    chk("R6 irq low only masked UE", {31'b0, irq}, 32'h0);
    wr(8'h0C, 32'h80);
    chk("R6 irq high UE unmasked", {31'b0, irq}, 32'h1);
    wr(8'h10, 32'hC0);
    rd_chk("R5 disable masks both", 8'h08, 32'hC0);
    chk("R6 irq low after disable", {31'b0, irq}, 32'h0);
    wr(8'h04, 32'hC0);
    rd_chk("R4 both cleared", 8'h04, 32'h0);
  endtask

  task automatic t_collision;
    @(negedge clk);
    ce_evt = 1'b1; err_addr = 18'h00777; err_data = 64'h7; err_syn = 8'h77;
    reg_wr_en = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h40;
    @(negedge clk);
    ce_evt = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0;
    rd_chk("R9 event beats clear", 8'h04, 32'h40);
    wr(8'h04, 32'h40);
    rd_chk("R9 cleared afterwards", 8'h04, 32'h0);
  endtask

  task automatic t_both;
    pulse(1'b1, 1'b1, 18'h2FEDC, 64'hCAFE_F00D_DEAD_BEEF, 8'hC3);
    rd_chk("R10 both status bits", 8'h04, 32'hC0);
    rd_chk("R10 CE addr", 8'h1C, 32'h0002FEDC);
    rd_chk("R10 UE addr", 8'h34, 32'h0002FEDC);
    rd_chk("R7 UE data lo", 8'h38, 32'hDEADBEEF);
    rd_chk("R7 UE data hi", 8'h3C, 32'hCAFEF00D);
    rd_chk("R7 UE syndrome", 8'h48, 32'h000000C3);
    wr(8'h04, 32'h80);
    pulse(1'b1, 1'b1, 18'h00005, 64'h55, 8'h05);
    rd_chk("R10 UE reloads alone", 8'h34, 32'h00000005);
    rd_chk("R10 CE held", 8'h1C, 32'h0002FEDC);
  endtask

  task automatic t_reserved;
    rd_chk("R11 offset 0x18", 8'h18, 32'h0);
    rd_chk("R11 offset 0x40", 8'h40, 32'h0);
    rd_chk("R11 offset 0x44", 8'h44, 32'h0);
    rd_chk("R11 offset 0x4C", 8'h4C, 32'h0);
    rd_chk("R11 offset 0xFC", 8'hFC, 32'h0);
    wr(8'h00, 32'hDEADBEEF);
    rd_chk("R12 error control readback", 8'h00, 32'hDEADBEEF);
    rd_chk("R12 status unchanged", 8'h04, 32'hC0);
    rd_chk("R12 mask unchanged", 8'h08, 32'hC0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ecc_gate();
    t_ce_capture();
    t_first_kept();
    t_w1c();
    t_mask_irq();
    t_collision();
    t_both();
    t_reserved();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule